// File: doc/BRIEF.md
# Serial Configuration Port Master

This block sits on the host side of a four-wire serial configuration link and turns one request on a valid/ready command interface into one complete 16-bit frame. A request carries a 7-bit register address, a write flag and a write byte. The block lowers the active-low select line and toggles the serial clock. It shifts out the address, then the write flag, then either the write byte or a run of zeros for a read. On a read it collects the byte that the attached device returns. When the frame is over, it holds select high for a programmable gap before it takes the next request. It never sequences more than one frame: a full configuration is a series of commands from the issuer.

The serial clock is derived from the system clock by counting. Each clock phase, low or high, lasts `HALF_CYC` system cycles, so `HALF_CYC` times the system period must be at least 50 ns. The first low phase runs with select already low, so the 25 ns select-to-first-rise margin is met whenever the half-period rule is met. Outgoing bits change only where the serial clock falls, or at frame start while it is low. Returned bits are taken at the system edge where the serial clock rises.

The controller is one state machine with five states. `ST_IDLE` waits with ready high. `ST_LOW` and `ST_HIGH` are the two halves of each bit slot. `ST_TAIL` keeps select low for one half-period after the last falling edge. `ST_GAP` keeps select high before returning to idle. The transitions are:
- accept: `ST_IDLE`→`ST_LOW` when valid is seen.
- rise: `ST_LOW`→`ST_HIGH` when the phase count expires.
- fall: `ST_HIGH`→`ST_LOW` when the phase count expires and bits remain.
- last: `ST_HIGH`→`ST_TAIL` after bit 16.
- release: `ST_TAIL`→`ST_GAP`, which also fires the done pulse.
- rearm: `ST_GAP`→`ST_IDLE`.

Top module: `cfg_port_master`

## Requirements
- R1: Out of reset, ready is 1, select (active low) is 1, the serial clock is 0, data-out is 0 and done is 0.
- R2: A command is taken on a system edge where valid and ready are both 1. Ready is 0 from the next cycle until the frame and its gap are over. Valid and the command fields presented while ready is 0 have no effect.
- R3: Frame bit order on data-out is: address bit 6 down to bit 0, then the direction bit (1 = write, 0 = read), then data bit 7 down to bit 0. Data-out changes only while the serial clock is low.
- R4: Each low and each high phase of the serial clock lasts exactly `HALF_CYC` system cycles. A frame has exactly 16 rising edges, and the first one comes after a full low phase with select already low.
- R5: For a read, data-out is 0 during the eight data slots. The input line is sampled at the system edge where the serial clock rises in slots 9 to 16, and the first sample becomes the MSB of the read byte.
- R6: After the 16th falling edge, select stays low with the clock low for `HALF_CYC` more cycles, then goes high. From acceptance to the rise of select takes 33·`HALF_CYC` cycles.
- R7: Done is a one-cycle pulse in the first cycle that select is high after a frame. With it, the read byte output holds the collected byte for a read and 0 for a write.
- R8: Select stays high for `GAP_CYC` cycles after a frame before ready returns to 1.
- R9: The serial clock is 0 whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can take a command |
| cmd_addr | input | 7 | Register address |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 8 | Byte to write (ignored on reads) |
| rsp_done | output | 1 | One-cycle end-of-frame pulse |
| rsp_rdata | output | 8 | Byte returned by a read, 0 after a write |
| port_sel_n | output | 1 | Frame select, active low |
| port_sclk | output | 1 | Serial clock |
| port_sdo | output | 1 | Serial data to the device |
| port_sdi | input | 1 | Serial data from the device |

## Verification
The bench builds the block with `HALF_CYC` = 7 and `GAP_CYC` = 9. At a 125 MHz system clock this gives 56 ns phases and a 72 ns gap, which is a legal timing. Because the two values differ, a mix-up between the phase count and the gap count changes the edge positions the reference predicts. The odd half-period also exposes off-by-one errors in the phase counter. With a frame of only 240 cycles, the bench can run back-to-back commands, reads with non-zero write bytes, and all-ones and all-zeros address patterns.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int CFGP_ADDR_W = 7;
    localparam int CFGP_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOW  = 3'd1,
        ST_HIGH = 3'd2,
        ST_TAIL = 3'd3,
        ST_GAP  = 3'd4
    } cfgp_state_t;
endpackage

// File: rtl/cfgp_timer.sv
module cfgp_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cfgp_shifter.sv
module cfgp_shifter #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          shift,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          sdi,
    output logic          msb,
    output logic          last,
    output logic          in_data,
    output logic          is_read,
    output logic [DW-1:0] rdata
);
    localparam int FW = AW + 1 + DW;
    localparam int IW = $clog2(FW);

    logic [FW-1:0] sh;
    logic [IW-1:0] idx;
    logic          rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            idx   <= '0;
            rd_q  <= 1'b0;
            rdata <= '0;
        end else if (load) begin
            sh    <= {addr, wr, (wr ? wdata : {DW{1'b0}})};
            idx   <= '0;
            rd_q  <= ~wr;
            rdata <= '0;
        end else begin
            if (shift) begin
                sh  <= {sh[FW-2:0], 1'b0};
                idx <= idx + 1'b1;
            end
            if (capture) begin
                rdata <= {rdata[DW-2:0], sdi};
            end
        end
    end

    assign msb     = sh[FW-1];
    assign last    = (idx == IW'(FW - 1));
    assign in_data = (idx >= IW'(AW + 1));
    assign is_read = rd_q;
endmodule

// File: rtl/cfg_port_master.sv
module cfg_port_master
    import cfgp_pkg::*;
#(
    parameter int HALF_CYC = 5,
    parameter int GAP_CYC  = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [CFGP_ADDR_W-1:0] cmd_addr,
    input  logic                   cmd_wr,
    input  logic [CFGP_DATA_W-1:0] cmd_wdata,
    output logic                   rsp_done,
    output logic [CFGP_DATA_W-1:0] rsp_rdata,
    output logic                   port_sel_n,
    output logic                   port_sclk,
    output logic                   port_sdo,
    input  logic                   port_sdi
);
    localparam int MAXC = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HALF_LD = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CYC - 1);

    cfgp_state_t state, nxt;

    logic          t_load, t_zero;
    logic [CW-1:0] t_val;
    logic          sh_load, sh_shift, sh_cap;
    logic          sh_msb, sh_last, sh_in_data, sh_is_read;
    logic          fin, done_q;

    cfgp_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    cfgp_shifter #(.AW(CFGP_ADDR_W), .DW(CFGP_DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (sh_load),
        .shift   (sh_shift),
        .capture (sh_cap),
        .addr    (cmd_addr),
        .wr      (cmd_wr),
        .wdata   (cmd_wdata),
        .sdi     (port_sdi),
        .msb     (sh_msb),
        .last    (sh_last),
        .in_data (sh_in_data),
        .is_read (sh_is_read),
        .rdata   (rsp_rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= fin;
    end

    // Transitions and datapath strobes
    always_comb begin
        nxt      = state;
        t_load   = 1'b0;
        t_val    = HALF_LD;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_cap   = 1'b0;
        fin      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    nxt     = ST_LOW;
                    t_load  = 1'b1;
                    sh_load = 1'b1;
                end
            end
            ST_LOW: begin
                if (t_zero) begin
                    nxt    = ST_HIGH;
                    t_load = 1'b1;
                    sh_cap = sh_is_read && sh_in_data;
                end
            end
            ST_HIGH: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    if (sh_last) begin
                        nxt = ST_TAIL;
                    end else begin
                        nxt      = ST_LOW;
                        sh_shift = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (t_zero) begin
                    nxt    = ST_GAP;
                    t_load = 1'b1;
                    t_val  = GAP_LD;
                    fin    = 1'b1;
                end
            end
            ST_GAP: begin
                if (t_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready  = 1'b0;
        port_sel_n = 1'b0;
        port_sclk  = 1'b0;
        port_sdo   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cmd_ready  = 1'b1;
                port_sel_n = 1'b1;
            end
            ST_LOW:  port_sdo = sh_msb;
            ST_HIGH: begin
                port_sclk = 1'b1;
                port_sdo  = sh_msb;
            end
            ST_TAIL: port_sel_n = 1'b0;
            ST_GAP:  port_sel_n = 1'b1;
            default: port_sel_n = 1'b1;
        endcase
    end

    assign rsp_done = done_q;

    // Checks
    assert_sclk_only_selected_R9: assert property (@(posedge clk) disable iff (rst)
        port_sclk |-> !port_sel_n);

    assert_ready_means_released_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> port_sel_n);

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_done_with_release_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (port_sel_n && !cmd_ready));

    assert_sdo_steady_high_R3: assert property (@(posedge clk) disable iff (rst)
        (port_sclk && $past(port_sclk)) |-> $stable(port_sdo));

    assert_select_before_clock_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(port_sel_n) |-> !port_sclk);

    generate
        if (HALF_CYC >= 2) begin : g_phase_chk
            assert_high_min_R4: assert property (@(posedge clk) disable iff (rst)
                $rose(port_sclk) |=> port_sclk);
            assert_low_min_R4: assert property (@(posedge clk) disable iff (rst)
                $fell(port_sclk) |=> !port_sclk);
        end
    endgenerate
endmodule

// File: tb/sim_cfg_port_master.sv
module sim_cfg_port_master;
    localparam int H = 7;
    localparam int G = 9;
    localparam int FRAME_END = 33 * H + G;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       cmd_valid = 1'b0;
    logic [6:0] cmd_addr  = '0;
    logic       cmd_wr    = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic       port_sdi;
    logic       cmd_ready, rsp_done, port_sel_n, port_sclk, port_sdo;
    logic [7:0] rsp_rdata;

    cfg_port_master #(.HALF_CYC(H), .GAP_CYC(G)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .port_sel_n(port_sel_n),
        .port_sclk(port_sclk), .port_sdo(port_sdo), .port_sdi(port_sdi)
    );

    // Reference model: t counts cycles since acceptance, -1 when idle
    integer      t = -1;
    logic [15:0] mframe = '0;
    logic        mwr = 1'b1;
    logic [7:0]  sbyte = '0;
    logic [7:0]  mbyte = '0;
    integer      nvec = 0;
    integer      nfail = 0;
    logic        armed = 1'b0;

    always @(posedge clk) begin
        armed = 1'b1;
        if (rst) begin
            t = -1;
        end else if (t < 0) begin
            if (cmd_valid) begin
                t      = 0;
                mframe = {cmd_addr, cmd_wr, (cmd_wr ? cmd_wdata : 8'h00)};
                mwr    = cmd_wr;
                mbyte  = sbyte;
            end
        end else begin
            t = t + 1;
            if (t == FRAME_END) t = -1;
        end
    end

    // Device model: drives its byte MSB first over slots 9..16 of a read
    always @* begin
        integer k;
        port_sdi = 1'b0;
        if (t >= 0 && t < 32 * H) begin
            k = t / (2 * H);
            if (!mwr && k >= 8) port_sdi = mbyte[15 - k];
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec = nvec + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%h expected=%h (t=%0d, time %0t)", tag, act, exp, t, $time);
        end
    endtask

    always @(negedge clk) begin
        logic e_ready, e_sel_n, e_sclk, e_sdo, e_done;
        if (armed) begin
            e_ready = (t < 0);
            e_sel_n = !(t >= 0 && t < 33 * H);
            e_sclk  = (t >= 0 && t < 32 * H && (t % (2 * H)) >= H);
            e_sdo   = (t >= 0 && t < 32 * H) ? mframe[15 - t / (2 * H)] : 1'b0;
            e_done  = (t == 33 * H);
            if (rst) begin
                chk("R1 ready",  {7'd0, cmd_ready},  {7'd0, 1'b1});
                chk("R1 sel_n",  {7'd0, port_sel_n}, {7'd0, 1'b1});
                chk("R1 sclk",   {7'd0, port_sclk},  8'd0);
                chk("R1 sdo",    {7'd0, port_sdo},   8'd0);
                chk("R1 done",   {7'd0, rsp_done},   8'd0);
            end else begin
                chk("R2/R8 ready", {7'd0, cmd_ready},  {7'd0, e_ready});
                chk("R6/R8 sel_n", {7'd0, port_sel_n}, {7'd0, e_sel_n});
                chk("R4/R9 sclk",  {7'd0, port_sclk},  {7'd0, e_sclk});
                chk("R3/R5 sdo",   {7'd0, port_sdo},   {7'd0, e_sdo});
                chk("R7 done",     {7'd0, rsp_done},   {7'd0, e_done});
                if (e_done) chk("R5/R7 rdata", rsp_rdata, mwr ? 8'h00 : mbyte);
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    task automatic send(input logic [6:0] a, input logic w, input logic [7:0] d, input logic [7:0] sb);
        sbyte     = sb;
        cmd_addr  = a;
        cmd_wr    = w;
        cmd_wdata = d;
        cmd_valid = 1'b1;
        do begin
            @(posedge clk);
            #2;
        end while (t != 0);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (t >= 0) begin
            @(posedge clk);
            #2;
        end
        repeat (3) @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 100000);
        nfail = nfail + 1;
        $display("FAIL watchdog expired (R2 ready never returned)");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        // R3: plain write
        send(7'h55, 1'b1, 8'hA3, 8'h00);
        wait_idle();
        // R5: read with a non-zero write byte that must not appear
        send(7'h2A, 1'b0, 8'hFF, 8'hC6);
        wait_idle();
        // R2/R8: valid stays high with new fields while busy -> back-to-back
        send(7'h7F, 1'b1, 8'hFF, 8'h00);
        cmd_valid = 1'b1;
        cmd_addr  = 7'h00;
        cmd_wr    = 1'b1;
        cmd_wdata = 8'h00;
        send(7'h00, 1'b1, 8'h00, 8'h00);
        wait_idle();
        // R5/R7: reads at address extremes, single-bit bytes
        send(7'h00, 1'b0, 8'h00, 8'h01);
        send(7'h7F, 1'b0, 8'h5A, 8'h80);
        wait_idle();
        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule